// File: doc/BRIEF.md
# Self-Refresh MR2 Update Sequencer

Before a DDR3 channel enters self-refresh, the mode register MR2 of every populated rank must be rewritten with a value that matches the temperature policy software has chosen. This block performs that rewrite. A software-written 16-bit shadow word supplies three things: the base MR2 contents, one self-refresh-temperature flag per DIMM, and one mirroring flag per DIMM. When the request arrives, the sequencer visits each present rank from lowest to highest index and drives one Mode Register Set command for each. It then waits for the mode-register settle time and raises a done level. The surrounding controller uses that level as permission to issue the self-refresh command.

The channel has two DIMMs of two ranks each, and rank r belongs to DIMM r/2. The second rank of a DIMM may be wired with address and bank mirroring. When software marks a DIMM as mirrored, the command to that DIMM's odd rank is sent with the pairs swapped, so the DRAM decodes it as an MR2 write. Even ranks are never mirrored. An unmirrored write to a mirrored rank would land in MR1.

The command bus is a command strobe, one chip select per rank, a bank field and an address field. Command spacing (tMrd) and the final settle wait (tMod) are given in clock cycles on input ports.

Top module: `sr_mr2_seq`

## Requirements
- R1: During and after reset, with no request pending, cmdValid, cmdCs, cmdBa and cmdAddr are all zero and srDone is low.
- R2: A request taken in idle produces exactly one command per rank whose rankPresent bit is set, in ascending rank order. The first command appears in the cycle after the request is sampled. Absent ranks get no command.
- R3: An unmirrored command carries bank code cmdBa = 3'b010 (MR2). Its cmdAddr[13:0] equals shadow[13:0] with bit 6 cleared, and with bit 7 replaced by the temperature flag of the rank's DIMM (shadow bit 6 for ranks 0/1, shadow bit 7 for ranks 2/3). cmdAddr bits above 13 are zero.
- R4: Commands to even ranks (0, 2) are always unmirrored, even when their DIMM's mirror flag is set.
- R5: A command to an odd rank whose DIMM mirror flag is set is mirrored. The mirror flag is shadow bit 14 for rank 1 and shadow bit 15 for rank 3. Mirroring swaps address bits 3/4, 5/6 and 7/8 of the R3 value and swaps bank bits 0/1, giving cmdBa = 3'b001. Undoing the swap yields the R3 command.
- R6: Consecutive commands start max(tMrd,1) cycles apart.
- R7: srDone rises max(tMod,1) cycles after the last command. It stays high while srReq is held, and falls one cycle after srReq is dropped.
- R8: If no rank is present, srDone rises in the cycle after the request is sampled, and no command is issued.
- R9: While cmdValid is high, cmdCs is one-hot on the addressed rank. Otherwise cmdCs is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srReq | input | 1 | Self-refresh entry request, held until srDone |
| rankPresent | input | 4 | One bit per populated rank |
| shadowReg | input | 16 | MR2 base [13:0], temperature flags [7:6], mirror flags [15:14] |
| tMrd | input | 8 | Cycles between consecutive MRS commands |
| tMod | input | 8 | Cycles from last MRS to done |
| cmdValid | output | 1 | Command strobe |
| cmdCs | output | 4 | Active-high chip select per rank |
| cmdBa | output | 3 | Bank address of the command |
| cmdAddr | output | 16 | Address of the command |
| srDone | output | 1 | Sequence complete, self-refresh may be entered |

## Verification
Several properties are checked on every cycle by the assertions:
- every command targets a present rank;
- even ranks never carry the mirrored bank code;
- chip selects stay one-hot under the strobe and quiet without it;
- the done level holds while the request is held and releases once the request is dropped.

Other behaviour can only be shown by the bench's scenarios, which compare each command against a schedule computed from the shadow word:
- the exact issue cycles under tMrd and tMod, including the zero and one cases;
- the skipping of absent ranks;
- the correct insertion of the temperature bit;
- that a mirrored command decodes back to MR2 once unswapped.

// File: rtl/sr_mr2_pkg.sv
package sr_mr2_pkg;
  localparam int NUM_RANKS = 4;
  localparam int RANK_W    = $clog2(NUM_RANKS);
  localparam int SHADOW_W  = 16;
  localparam logic [2:0] MR2_BANK = 3'b010;

  typedef struct packed {
    logic              issue;
    logic [RANK_W-1:0] rank;
  } seqStrobe_t;
endpackage

// File: rtl/sr_mr2_ctl.sv
module sr_mr2_ctl
  import sr_mr2_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 srReq,
  input  logic [NUM_RANKS-1:0] rankPresent,
  input  logic [CNT_W-1:0]     tMrd,
  input  logic [CNT_W-1:0]     tMod,
  output seqStrobe_t           strobe,
  output logic                 srDone
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t            state;
  logic [RANK_W-1:0] rank;
  logic [CNT_W-1:0]  cnt;
  logic              lastCmd;

  logic              firstFound, nextFound;
  logic [RANK_W-1:0] firstIdx, nextIdx;
  logic [CNT_W-1:0]  gapSel;

  // lowest present rank overall and lowest present rank above the current one
  always_comb begin
    firstFound = 1'b0;
    firstIdx   = '0;
    nextFound  = 1'b0;
    nextIdx    = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (rankPresent[i]) begin
        firstFound = 1'b1;
        firstIdx   = RANK_W'(i);
        if (i > int'(rank)) begin
          nextFound = 1'b1;
          nextIdx   = RANK_W'(i);
        end
      end
    end
  end

  assign gapSel = nextFound ? tMrd : tMod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rank    <= '0;
      cnt     <= '0;
      lastCmd <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (srReq) begin
          if (firstFound) begin
            rank  <= firstIdx;
            state <= S_ISSUE;
          end else begin
            state <= S_DONE;
          end
        end
        S_ISSUE: begin
          lastCmd <= !nextFound;
          if (nextFound) rank <= nextIdx;
          if (gapSel <= CNT_W'(1)) begin
            state <= nextFound ? S_ISSUE : S_DONE;
          end else begin
            cnt   <= gapSel - CNT_W'(2);
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cnt == '0) state <= lastCmd ? S_DONE : S_ISSUE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        S_DONE: if (!srReq) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strobe.issue = (state == S_ISSUE);
  assign strobe.rank  = rank;
  assign srDone       = (state == S_DONE);

  // R2: every command is addressed to a populated rank
  assert_issue_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |-> rankPresent[strobe.rank]);

  // R6: with a spacing of two or more, a command is never followed at once by another
  assert_mrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.issue && nextFound && tMrd >= CNT_W'(2)) |=> !strobe.issue);

  // R7: done is held while the request stays high
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srDone && srReq) |=> srDone);

  // R7: done releases one cycle after the request drops
  assert_done_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srDone && !srReq) |=> !srDone);
endmodule

// File: rtl/sr_mr2_dp.sv
module sr_mr2_dp
  import sr_mr2_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seqStrobe_t           strobe,
  input  logic [SHADOW_W-1:0]  shadowReg,
  output logic                 cmdValid,
  output logic [NUM_RANKS-1:0] cmdCs,
  output logic [BANK_W-1:0]    cmdBa,
  output logic [ADDR_W-1:0]    cmdAddr
);
  localparam int MR_BITS   = 14;
  localparam int SWAP_PAIRS = 3;

  logic              dimmSel, oddRank, srtBit, mirBit, mirror;
  logic [ADDR_W-1:0] addrPlain, addrMir;
  logic [BANK_W-1:0] baPlain, baMir;

  assign dimmSel = strobe.rank[RANK_W-1];
  assign oddRank = strobe.rank[0];
  assign srtBit  = dimmSel ? shadowReg[7]  : shadowReg[6];
  assign mirBit  = dimmSel ? shadowReg[15] : shadowReg[14];
  assign mirror  = oddRank & mirBit;

  always_comb begin
    addrPlain = '0;
    addrPlain[MR_BITS-1:0] = {shadowReg[13:8], srtBit, 1'b0, shadowReg[5:0]};
    baPlain = '0;
    baPlain[2:0] = MR2_BANK;
  end

  // address pair swaps A3/A4, A5/A6, A7/A8
  always_comb begin
    addrMir = addrPlain;
    for (int k = 0; k < SWAP_PAIRS; k++) begin
      addrMir[3 + 2*k] = addrPlain[4 + 2*k];
      addrMir[4 + 2*k] = addrPlain[3 + 2*k];
    end
    baMir    = baPlain;
    baMir[0] = baPlain[1];
    baMir[1] = baPlain[0];
  end

  generate
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cs
      assign cmdCs[r] = strobe.issue && (strobe.rank == RANK_W'(r));
    end
  endgenerate

  assign cmdValid = strobe.issue;
  assign cmdAddr  = !strobe.issue ? '0 : (mirror ? addrMir : addrPlain);
  assign cmdBa    = !strobe.issue ? '0 : (mirror ? baMir   : baPlain);

  // R1: bus quiet without a command
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |-> (cmdAddr == '0 && cmdBa == '0 && cmdCs == '0));

  // R4: even ranks always see the plain MR2 bank code
  assert_even_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !strobe.rank[0]) |-> cmdBa == BANK_W'(MR2_BANK));

  // R5: any command decodes to MR2, directly or after the bank swap
  assert_bank_mr2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> (cmdBa == BANK_W'(3'b010) || cmdBa == BANK_W'(3'b001)));

  // R9: exactly one chip select under the strobe
  assert_cs_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> $countones(cmdCs) == 1);
endmodule

// File: rtl/sr_mr2_seq.sv
module sr_mr2_seq
  import sr_mr2_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 srReq,
  input  logic [NUM_RANKS-1:0] rankPresent,
  input  logic [SHADOW_W-1:0]  shadowReg,
  input  logic [CNT_W-1:0]     tMrd,
  input  logic [CNT_W-1:0]     tMod,
  output logic                 cmdValid,
  output logic [NUM_RANKS-1:0] cmdCs,
  output logic [BANK_W-1:0]    cmdBa,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic                 srDone
);
  seqStrobe_t strobe;

  sr_mr2_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .srReq(srReq), .rankPresent(rankPresent),
    .tMrd(tMrd), .tMod(tMod), .strobe(strobe), .srDone(srDone)
  );

  sr_mr2_dp #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .shadowReg(shadowReg),
    .cmdValid(cmdValid), .cmdCs(cmdCs), .cmdBa(cmdBa), .cmdAddr(cmdAddr)
  );
endmodule

// File: tb/sr_mr2_seq_tb.sv
module sr_mr2_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        srReq;
  logic [3:0]  rankPresent;
  logic [15:0] shadowReg;
  logic [7:0]  tMrd, tMod;
  logic        cmdValid;
  logic [3:0]  cmdCs;
  logic [2:0]  cmdBa;
  logic [15:0] cmdAddr;
  logic        srDone;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sr_mr2_seq dut_i (
    .clk(clk), .rst_n(rst_n), .srReq(srReq), .rankPresent(rankPresent),
    .shadowReg(shadowReg), .tMrd(tMrd), .tMod(tMod), .cmdValid(cmdValid),
    .cmdCs(cmdCs), .cmdBa(cmdBa), .cmdAddr(cmdAddr), .srDone(srDone)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nextPresent(input logic [3:0] pres, input int after);
    for (int i = after + 1; i < 4; i++) if (pres[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] expPlain(input int r, input logic [15:0] sh);
    logic [15:0] a;
    a = {2'b00, sh[13:0]};
    a[6] = 1'b0;
    a[7] = sh[6 + r/2];
    return a;
  endfunction

  function automatic logic isMir(input int r, input logic [15:0] sh);
    return (r % 2 == 1) && sh[14 + r/2];
  endfunction

  function automatic logic [15:0] swapAddr(input logic [15:0] a);
    logic [15:0] s;
    s = a;
    s[3] = a[4]; s[4] = a[3];
    s[5] = a[6]; s[6] = a[5];
    s[7] = a[8]; s[8] = a[7];
    return s;
  endfunction

  function automatic int atLeast1(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic runSeq(input logic [3:0] pres, input logic [15:0] sh,
                        input logic [7:0] mrd, input logic [7:0] mod);
    int r, cmdAt, doneAt, r2;
    logic [2:0]  eBa;
    logic [15:0] eAddr;
    @(negedge clk);
    rankPresent = pres; shadowReg = sh; tMrd = mrd; tMod = mod; srReq = 1'b1;
    r = nextPresent(pres, -1);
    cmdAt = 1;
    doneAt = (r < 0) ? 1 : 1000000;
    for (int n = 1; n <= 5000; n++) begin
      @(negedge clk);
      if (r >= 0 && n == cmdAt) begin
        eAddr = expPlain(r, sh);
        eBa   = 3'b010;
        if (isMir(r, sh)) begin
          eAddr = swapAddr(eAddr);
          eBa   = 3'b001;
        end
        check("R2 command strobe", {31'b0, cmdValid}, 32'd1);
        check("R9 chip select", {28'b0, cmdCs}, 32'd1 << r);
        if (isMir(r, sh)) begin
          check("R5 mirrored bank", {29'b0, cmdBa}, {29'b0, eBa});
          check("R5 mirrored addr", {16'b0, cmdAddr}, {16'b0, eAddr});
          check("R5 decodes to MR2", {29'b0, cmdBa[2], cmdBa[0], cmdBa[1]}, 32'd2);
        end else if (r % 2 == 0) begin
          check("R4 even bank", {29'b0, cmdBa}, {29'b0, eBa});
          check("R4 even addr", {16'b0, cmdAddr}, {16'b0, eAddr});
        end else begin
          check("R3 bank", {29'b0, cmdBa}, {29'b0, eBa});
          check("R3 addr", {16'b0, cmdAddr}, {16'b0, eAddr});
        end
        r2 = nextPresent(pres, r);
        if (r2 >= 0) cmdAt = n + atLeast1(mrd);
        else         doneAt = n + atLeast1(mod);
        r = r2;
      end else begin
        check("R6 no command between slots", {31'b0, cmdValid}, 32'd0);
      end
      if (pres == 4'b0) check("R8 immediate done", {31'b0, srDone}, 32'd1);
      else check("R7 done timing", {31'b0, srDone}, {31'b0, (n >= doneAt)});
      if (n >= doneAt) break;
    end
    @(negedge clk);
    check("R7 done held", {31'b0, srDone}, 32'd1);
    srReq = 1'b0;
    @(negedge clk);
    check("R7 done released", {31'b0, srDone}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seedVal;
    seedVal = $urandom(32'd20201210);
    rst_n = 1'b0; srReq = 1'b0; rankPresent = 4'hF; shadowReg = 16'h0;
    tMrd = 8'd4; tMod = 8'd12;
    repeat (3) @(negedge clk);
    check("R1 reset strobe", {31'b0, cmdValid}, 32'd0);
    check("R1 reset cs", {28'b0, cmdCs}, 32'd0);
    check("R1 reset done", {31'b0, srDone}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle quiet", {16'b0, cmdAddr}, 32'd0);

    // directed corners
    runSeq(4'hF, 16'hFFFF, 8'd4, 8'd12);   // all mirrored/srt flags set
    runSeq(4'hF, 16'h3F3F, 8'd0, 8'd0);    // zero gaps behave as one
    runSeq(4'hF, 16'h0000, 8'd1, 8'd1);
    runSeq(4'h0, 16'hC0C0, 8'd5, 8'd9);    // no ranks
    runSeq(4'b1000, 16'h8000, 8'd3, 8'd2); // only rank 3, mirrored
    runSeq(4'b0101, 16'hC000, 8'd2, 8'd3); // even ranks, mirror flags ignored
    runSeq(4'b0110, 16'h4155, 8'd7, 8'd4);

    // constrained random
    for (int it = 0; it < 40; it++) begin
      runSeq(4'($urandom), 16'($urandom), 8'($urandom % 16), 8'($urandom % 16));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule